// File: doc/BRIEF.md
# Serial Baud Generator with Voted Receive Sampling

This block produces the bit timing for a serial port that runs either as an asynchronous link or as a synchronous clock master. An 8-bit divisor X reloads a free-running down-counter. The counter's zero crossings form a prescaler tick. A post-divider then stretches that tick into the bit-rate tick. The post-divider ratio is 64 for low-speed asynchronous operation, 16 for high-speed asynchronous operation and 4 for synchronous master operation. In synchronous mode the high-speed select has no effect.

In asynchronous modes the block also emits an oversample tick at sixteen times the bit rate. A receive sampler takes the line through a two-flop synchroniser and captures it at three instants near the centre of each bit. It then reports the majority of those three samples with a one-cycle valid strobe. Writing a new divisor restarts the whole timing chain at once, so the new rate applies from the write onward.

Top module: `sercom_baud_core`

## Requirements
- R1: While `rst_n` is low, `baud_tick`, `os_tick` and `rx_valid` are all low.
- R2: With `sync_mode`=0 and `fast_sel`=0, `baud_tick` pulses once every 64·(X+1) clock cycles.
- R3: With `sync_mode`=0 and `fast_sel`=1, `baud_tick` pulses once every 16·(X+1) clock cycles.
- R4: With `sync_mode`=1, `baud_tick` pulses once every 4·(X+1) clock cycles, whatever the value of `fast_sel`.
- R5: A cycle with `div_wr`=1 produces no tick. The first `baud_tick` after it appears exactly ratio·(X+1) rising edges after the write edge, regardless of where the previous period stood.
- R6: In asynchronous modes `os_tick` pulses exactly 16 times per bit period, and its last pulse lands in the same cycle as `baud_tick`. In synchronous mode `os_tick` stays low.
- R7: The sampling instants are oversample ticks 7, 8 and 9 (counting from 0) of each asynchronous bit, or prescaler ticks 1, 2 and 3 of each synchronous bit. At each instant the line value used is the one that `rx_in` had two rising edges earlier.
- R8: `rx_bit` equals the value held by at least two of the three samples, so a single disagreeing sample is outvoted.
- R9: `rx_valid` is a one-cycle pulse, registered in the cycle after the third sample of each bit, and `rx_bit` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Divisor write strobe; restarts the timing chain |
| div_val | input | 8 | Divisor value X (0 to 255) |
| sync_mode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| fast_sel | input | 1 | High-speed select for asynchronous mode |
| rx_in | input | 1 | Receive line |
| baud_tick | output | 1 | One-cycle pulse per bit period |
| os_tick | output | 1 | One-cycle pulse per sixteenth of an asynchronous bit |
| rx_bit | output | 1 | Majority-voted received bit |
| rx_valid | output | 1 | One-cycle strobe qualifying `rx_bit` |

## Verification
The hardest case to reach from the ports is a disturbance on the receive line that hits exactly one chosen sampling instant and no other. The stimulus sets this up with a divisor write, which puts the phase counter in a known state on a known edge. With X=0 in high-speed asynchronous mode, every cycle is one oversample step. The bench therefore computes, counting the synchroniser delay, which drive cycle each of the three samples reads. It then flips the line on any subset of those cycles. The same alignment with X=1 covers the synchronous sampling slots. Tick periods are measured against every divisor write issued part-way through a running period, so each measurement also covers the restart.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

   typedef enum logic [1:0] {
      SBG_ASYNC_SLOW = 2'd0,
      SBG_ASYNC_FAST = 2'd1,
      SBG_SYNC       = 2'd2
   } sbg_mode_e;

   function automatic sbg_mode_e sbg_decode(input logic sync_sel, input logic fast);
      if (sync_sel)  return SBG_SYNC;
      else if (fast) return SBG_ASYNC_FAST;
      else           return SBG_ASYNC_SLOW;
   endfunction

   function automatic logic sbg_vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/sbg_reload_timer.sv
module sbg_reload_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [DIV_W-1:0] load_val,
   output logic             pre_tick
);

   logic [DIV_W-1:0] reload_q;
   logic [DIV_W-1:0] count_q;
   logic             at_zero;

   assign at_zero  = (count_q == '0);
   assign pre_tick = at_zero & ~load_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         count_q  <= '0;
      end else if (load_en) begin
         reload_q <= load_val;
         count_q  <= load_val;
      end else if (at_zero) begin
         count_q  <= reload_q;
      end else begin
         count_q  <= count_q - 1'b1;
      end
   end

endmodule

// File: rtl/sbg_phase_div.sv
module sbg_phase_div
   import sbg_pkg::*;
#(
   parameter int OS_PER_BIT  = 16,
   parameter int SLOW_OS_DIV = 4,
   parameter int SYNC_DIV    = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  logic      pre_tick,
   input  sbg_mode_e mode,
   output logic      baud_tick,
   output logic      os_tick,
   output logic [2:0] samp_evt
);

   localparam int RATIO_SLOW = OS_PER_BIT * SLOW_OS_DIV;
   localparam int RATIO_FAST = OS_PER_BIT;
   localparam int RATIO_SYNC = SYNC_DIV;
   localparam int PH_W       = $clog2(RATIO_SLOW);
   localparam int SUB_W      = $clog2(SLOW_OS_DIV);
   localparam int MID        = OS_PER_BIT / 2;
   localparam int A_BASE     = MID - 1;
   localparam int S_BASE     = SYNC_DIV - 3;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] last_ph;
   logic [PH_W-1:0] k_idx;
   logic [PH_W-1:0] k_base;
   logic            wrap;
   logic            sub_done;
   logic            slot_ok;
   logic            os_evt;
   logic            baud_q;
   logic            os_q;

   assign sub_done = ((phase_q & PH_W'(SLOW_OS_DIV - 1)) == PH_W'(SLOW_OS_DIV - 1));

   always_comb begin
      case (mode)
         SBG_ASYNC_FAST: begin
            last_ph = PH_W'(RATIO_FAST - 1);
            k_idx   = phase_q & PH_W'(OS_PER_BIT - 1);
            k_base  = PH_W'(A_BASE);
            slot_ok = 1'b1;
            os_evt  = pre_tick;
         end
         SBG_SYNC: begin
            last_ph = PH_W'(RATIO_SYNC - 1);
            k_idx   = phase_q & PH_W'(SYNC_DIV - 1);
            k_base  = PH_W'(S_BASE);
            slot_ok = 1'b1;
            os_evt  = 1'b0;
         end
         default: begin
            last_ph = PH_W'(RATIO_SLOW - 1);
            k_idx   = phase_q >> SUB_W;
            k_base  = PH_W'(A_BASE);
            slot_ok = sub_done;
            os_evt  = pre_tick & sub_done;
         end
      endcase
   end

   assign wrap = (phase_q >= last_ph);

   for (genvar g = 0; g < 3; g++) begin : g_slot
      assign samp_evt[g] = pre_tick & slot_ok & (k_idx == k_base + PH_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         baud_q  <= 1'b0;
         os_q    <= 1'b0;
      end else if (restart) begin
         phase_q <= '0;
         baud_q  <= 1'b0;
         os_q    <= 1'b0;
      end else begin
         if (pre_tick) phase_q <= wrap ? '0 : phase_q + 1'b1;
         baud_q <= pre_tick & wrap;
         os_q   <= os_evt;
      end
   end

   assign baud_tick = baud_q;
   assign os_tick   = os_q;

endmodule

// File: rtl/sbg_majority_rx.sv
module sbg_majority_rx
   import sbg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       rx_in,
   input  logic [2:0] samp_evt,
   output logic       rx_bit,
   output logic       rx_valid
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [1:0]             held_q;
   logic                   rx_s;
   logic                   bit_q;
   logic                   valid_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= rx_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b1;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign rx_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= '0;
         bit_q   <= 1'b1;
         valid_q <= 1'b0;
      end else if (restart) begin
         held_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (samp_evt[0]) held_q[0] <= rx_s;
         if (samp_evt[1]) held_q[1] <= rx_s;
         if (samp_evt[2]) bit_q     <= sbg_vote3(held_q[0], held_q[1], rx_s);
         valid_q <= samp_evt[2];
      end
   end

   assign rx_bit   = bit_q;
   assign rx_valid = valid_q;

endmodule

// File: rtl/sercom_baud_core.sv
module sercom_baud_core
   import sbg_pkg::*;
#(
   parameter int DIV_W          = 8,
   parameter int RX_SYNC_STAGES = 2,
   parameter int OS_PER_BIT     = 16,
   parameter int SLOW_OS_DIV    = 4,
   parameter int SYNC_DIV       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_val,
   input  logic             sync_mode,
   input  logic             fast_sel,
   input  logic             rx_in,
   output logic             baud_tick,
   output logic             os_tick,
   output logic             rx_bit,
   output logic             rx_valid
);

   localparam bit OS_POW2   = (OS_PER_BIT  & (OS_PER_BIT  - 1)) == 0;
   localparam bit SUB_POW2  = (SLOW_OS_DIV & (SLOW_OS_DIV - 1)) == 0;
   localparam bit SYNC_POW2 = (SYNC_DIV    & (SYNC_DIV    - 1)) == 0;

   if (DIV_W < 1) begin : g_bad_div
      $error("sercom_baud_core: DIV_W must be at least 1");
   end
   if (RX_SYNC_STAGES < 1) begin : g_bad_sync
      $error("sercom_baud_core: RX_SYNC_STAGES must be at least 1");
   end
   if (OS_PER_BIT < 4 || !OS_POW2) begin : g_bad_os
      $error("sercom_baud_core: OS_PER_BIT must be a power of two, 4 or more");
   end
   if (SLOW_OS_DIV < 2 || !SUB_POW2) begin : g_bad_sub
      $error("sercom_baud_core: SLOW_OS_DIV must be a power of two, 2 or more");
   end
   if (SYNC_DIV < 4 || !SYNC_POW2 || SYNC_DIV > OS_PER_BIT * SLOW_OS_DIV) begin : g_bad_sdiv
      $error("sercom_baud_core: SYNC_DIV must be a power of two within the slow ratio");
   end

   sbg_mode_e mode;
   logic      pre_tick;
   logic [2:0] samp_evt;

   assign mode = sbg_decode(sync_mode, fast_sel);

   sbg_reload_timer #(
      .DIV_W    (DIV_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (div_wr),
      .load_val (div_val),
      .pre_tick (pre_tick)
   );

   sbg_phase_div #(
      .OS_PER_BIT  (OS_PER_BIT),
      .SLOW_OS_DIV (SLOW_OS_DIV),
      .SYNC_DIV    (SYNC_DIV)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (div_wr),
      .pre_tick  (pre_tick),
      .mode      (mode),
      .baud_tick (baud_tick),
      .os_tick   (os_tick),
      .samp_evt  (samp_evt)
   );

   sbg_majority_rx #(
      .SYNC_STAGES (RX_SYNC_STAGES)
   ) u_vote (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (div_wr),
      .rx_in    (rx_in),
      .samp_evt (samp_evt),
      .rx_bit   (rx_bit),
      .rx_valid (rx_valid)
   );

endmodule

// File: rtl/sercom_baud_core_chk.sv
module sercom_baud_core_chk (
   input logic clk,
   input logic rst_n,
   input logic div_wr,
   input logic sync_mode,
   input logic baud_tick,
   input logic os_tick,
   input logic rx_valid
);

   // R1
   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> (!baud_tick && !os_tick && !rx_valid));

   // R5
   a_r5_no_tick_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(div_wr) |-> (!baud_tick && !os_tick && !rx_valid));

   // R6
   a_r6_baud_on_os: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && !$past(sync_mode)) |-> os_tick);

   // R6
   a_r6_no_os_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_mode) |-> !os_tick);

   // R9
   a_r9_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

bind sercom_baud_core sercom_baud_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .div_wr    (div_wr),
   .sync_mode (sync_mode),
   .baud_tick (baud_tick),
   .os_tick   (os_tick),
   .rx_valid  (rx_valid)
);

// File: tb/sercom_baud_core_bench.sv
`timescale 1ns/1ps
module sercom_baud_core_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_wr = 1'b0;
   logic [7:0] div_val = 8'd0;
   logic       sync_mode = 1'b0;
   logic       fast_sel = 1'b0;
   logic       rx_in = 1'b1;
   logic       baud_tick;
   logic       os_tick;
   logic       rx_bit;
   logic       rx_valid;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  mon_en = 1'b0;
   bit  done   = 1'b0;
   logic exp_q[$];

   always #2 clk = ~clk;

   sercom_baud_core u_sercom_baud_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_wr    (div_wr),
      .div_val   (div_val),
      .sync_mode (sync_mode),
      .fast_sel  (fast_sel),
      .rx_in     (rx_in),
      .baud_tick (baud_tick),
      .os_tick   (os_tick),
      .rx_bit    (rx_bit),
      .rx_valid  (rx_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // write a divisor and mode; returns at the negedge after the write edge
   task automatic do_write(input int x, input logic sy, input logic fs);
      @(negedge clk);
      div_val   = 8'(x);
      sync_mode = sy;
      fast_sel  = fs;
      div_wr    = 1'b1;
      @(negedge clk);
      div_wr    = 1'b0;
   endtask

   // R2 R3 R4 R5 R6: latency after write, period, oversample count
   task automatic measure(input int x, input logic sy, input logic fs, input string req);
      int ratio;
      int n;
      int m;
      int os_n;
      ratio = sy ? 4 : (fs ? 16 : 64);
      do_write(x, sy, fs);
      n = 1;
      while (!baud_tick) begin
         @(negedge clk);
         n++;
      end
      chk(n - 1 == ratio * (x + 1), "R5 first tick after write", n - 1, ratio * (x + 1));
      m = 0;
      os_n = 0;
      do begin
         @(negedge clk);
         m++;
         if (os_tick) os_n++;
      end while (!baud_tick);
      chk(m == ratio * (x + 1), req, m, ratio * (x + 1));
      chk(os_n == (sy ? 0 : 16), "R6 oversample ticks per bit", os_n, sy ? 0 : 16);
   endtask

   // scoreboard driver: one bit, flipping the line on chosen sample slots
   task automatic send_bit(input int len, input int o0, input int o1, input int o2,
                           input logic lvl, input logic [2:0] flip);
      int ones;
      ones = 0;
      for (int j = 0; j < 3; j++) if (lvl ^ flip[j]) ones++;
      exp_q.push_back(ones >= 2);   // R8 majority of three
      for (int i = 0; i < len; i++) begin
         if      (i == o0) rx_in = lvl ^ flip[0];
         else if (i == o1) rx_in = lvl ^ flip[1];
         else if (i == o2) rx_in = lvl ^ flip[2];
         else              rx_in = lvl;
         @(negedge clk);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_en && rx_valid && exp_q.size() > 0) begin
         logic e;
         e = exp_q.pop_front();
         chk(rx_bit == e, "R7 R8 R9 voted bit", int'(rx_bit), int'(e));
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (baud_tick || os_tick || rx_valid) quiet = 1'b0;
      end
      chk(quiet, "R1 outputs low in reset", int'(quiet), 1);
      rst_n = 1'b1;

      // slow asynchronous; the X=40 run leaves a period half done for R5
      measure(0,   1'b0, 1'b0, "R2 slow period");
      do_write(40, 1'b0, 1'b0);
      repeat (1000) @(negedge clk);
      measure(2,   1'b0, 1'b0, "R2 slow period");
      measure(5,   1'b0, 1'b0, "R2 slow period");
      measure(255, 1'b0, 1'b0, "R2 slow period");
      // fast asynchronous
      measure(0,   1'b0, 1'b1, "R3 fast period");
      measure(9,   1'b0, 1'b1, "R3 fast period");
      measure(200, 1'b0, 1'b1, "R3 fast period");
      // synchronous, speed select ignored
      measure(0,   1'b1, 1'b0, "R4 sync period");
      measure(5,   1'b1, 1'b0, "R4 sync period speed low");
      measure(5,   1'b1, 1'b1, "R4 sync period speed high");
      measure(77,  1'b1, 1'b1, "R4 sync period");

      // R7 R8 asynchronous: X=0 fast, samples read drive offsets 5,6,7 of 16
      mon_en = 1'b1;
      do_write(0, 1'b0, 1'b1);
      for (int b = 0; b < 16; b++) begin
         send_bit(16, 5, 6, 7, logic'(b[0]), 3'(b >> 1));
      end
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R9 one strobe per async bit", exp_q.size(), 0);
      exp_q.delete();

      // R7 R8 synchronous: X=1, samples read drive offsets 1,3,5 of 8
      do_write(1, 1'b1, 1'b0);
      for (int b = 0; b < 16; b++) begin
         send_bit(8, 1, 3, 5, logic'(~b[0]), 3'(b >> 1));
      end
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R9 one strobe per sync bit", exp_q.size(), 0);
      mon_en = 1'b0;
      exp_q.delete();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule